// File: doc/BRIEF.md
# Deferred Display Control Register Latch

This block stores the display control registers that the host CPU writes, and it decides when each value reaches the video pipeline. Most fields go to the display logic on the clock after the write: the background colour, the vertical display offset and four table base addresses. Three kinds of field need more care: the five screen-mode bits, the blank flag and the sprite-disable flag. A change to any of these in the middle of a line could corrupt the fetch pattern of that line. Writes to them therefore go into shadow storage. The shadow copy moves into the active copy once per line, on a fixed cycle of horizontal blanking.

The host drives a write port with an address, data and a single-cycle strobe. The video timing generator supplies the per-line cycle counter, which is 0 at the start of horizontal sync. Software can write a mode change at any point in a line, and it takes effect cleanly at the next commit point.

Top module: `disp_ctrl_latch`

## Requirements
- R1: While `rst_ni` is low, and until the first write after it, `blank_o` is 1, and `mode_o`, `sprite_off_o` and all six immediate outputs are 0.
- R2: The deferred fields sit at address 0x00. Bits [4:0] are the mode, bit 5 is blank and bit 6 is sprite disable; bit 7 is ignored. A write there does not change the deferred outputs before the next commit edge.
- R3: The deferred outputs change only on the clock edge where `hcnt_i` equals `COMMIT_CYCLE` (default 144). The new value is visible from the cycle after that edge.
- R4: At a commit edge the deferred outputs take the last value written to address 0x00 before that edge. Earlier writes in the same line are discarded.
- R5: A write to address 0x00 on the commit cycle itself is included in that commit. A write one cycle later waits for the next line's commit.
- R6: The immediate registers sit at these addresses: 0x01 background colour, 0x02 vertical offset, 0x03 name table base, 0x04 colour table base, 0x05 pattern table base, 0x06 sprite table base. Each output shows the written byte from the cycle after the strobe, at any value of `hcnt_i`.
- R7: Writes to addresses 0x07 to 0x3F change no output.
- R8: A commit with no write since the previous commit leaves the deferred outputs unchanged.
- R9: Address and data presented while `wr_en_i` is low have no effect on any output, including at a commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_addr_i | input | ADDR_W (6) | Register address |
| wr_data_i | input | DATA_W (8) | Write data |
| hcnt_i | input | HCNT_W (11) | Cycle within the line, 0 at start of horizontal sync |
| mode_o | output | 5 | Effective screen-mode bits (deferred) |
| blank_o | output | 1 | Effective blank flag (deferred) |
| sprite_off_o | output | 1 | Effective sprite disable (deferred) |
| bg_color_o | output | DATA_W | Background colour |
| vofs_o | output | DATA_W | Vertical display offset |
| name_base_o | output | DATA_W | Name table base |
| color_base_o | output | DATA_W | Colour table base |
| pattern_base_o | output | DATA_W | Pattern table base |
| sprite_base_o | output | DATA_W | Sprite table base |

## Verification
The bench places writes to the deferred register one cycle before the commit cycle, on it, and one cycle after it. A design that compared the counter off by one would commit a write one line early or one line late. Several writes inside a single line check that only the last one is applied, which catches a design that commits the first write or ORs the writes together. A sweep over all 64 addresses with writes at many line positions, compared every cycle against an arithmetic model, catches aliasing between addresses, deferred fields leaking through at once, and immediate fields that wait for blanking. The sweep also shows whether writes without the strobe are ignored.

// File: rtl/disp_ctrl_pkg.sv
package disp_ctrl_pkg;

  localparam int unsigned MODE_W     = 5;
  localparam int unsigned NUM_IMM    = 6;
  localparam int unsigned DEFER_ADDR = 0;
  localparam int unsigned IMM_BASE   = 1;

  typedef enum int unsigned {
    IMM_BG    = 0,
    IMM_VOFS  = 1,
    IMM_NAME  = 2,
    IMM_COLOR = 3,
    IMM_PAT   = 4,
    IMM_SPR   = 5
  } imm_idx_e;

  // bit order of the struct matches the write data layout at DEFER_ADDR
  typedef struct packed {
    logic              sprite_off;
    logic              blank;
    logic [MODE_W-1:0] mode;
  } defer_t;

  localparam int unsigned DEFER_W = $bits(defer_t);

  localparam defer_t DEFER_RST = '{sprite_off: 1'b0, blank: 1'b1, mode: '0};

endpackage

// File: rtl/dcr_wr_decode.sv
module dcr_wr_decode
  import disp_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              def_we_o,
  output logic [NUM_IMM-1:0] imm_we_o
);

  localparam logic [ADDR_W-1:0] DefAddr = ADDR_W'(DEFER_ADDR);

  assign def_we_o = wr_en_i && (wr_addr_i == DefAddr);

  for (genvar i = 0; i < NUM_IMM; i++) begin : g_imm_dec
    localparam logic [ADDR_W-1:0] ImmAddr = ADDR_W'(IMM_BASE + i);
    assign imm_we_o[i] = wr_en_i && (wr_addr_i == ImmAddr);
  end

endmodule

// File: rtl/dcr_imm_bank.sv
module dcr_imm_bank
  import disp_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_IMM-1:0]              we_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [NUM_IMM-1:0][DATA_W-1:0]  q_o
);

  for (genvar i = 0; i < NUM_IMM; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o[i] <= '0;
      else if (we_i[i]) q_o[i] <= wdata_i;
    end

    AST_IMM_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[i] |=> q_o[i] == $past(wdata_i)); // R6
    AST_IMM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i[i] |=> $stable(q_o[i])); // R9
  end

endmodule

// File: rtl/dcr_defer_stage.sv
module dcr_defer_stage
  import disp_ctrl_pkg::*;
#(
  parameter int unsigned HCNT_W       = 11,
  parameter int unsigned COMMIT_CYCLE = 144
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  defer_t            wdata_i,
  input  logic [HCNT_W-1:0] hcnt_i,
  output defer_t            active_o
);

  localparam logic [HCNT_W-1:0] CommitAt = HCNT_W'(COMMIT_CYCLE);

  defer_t shadow_q, shadow_d, active_q;
  logic   commit;

  assign commit   = (hcnt_i == CommitAt);
  // same-cycle write bypasses into the commit
  assign shadow_d = we_i ? wdata_i : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= DEFER_RST;
      active_q <= DEFER_RST;
    end else begin
      shadow_q <= shadow_d;
      if (commit) active_q <= shadow_d;
    end
  end

  assign active_o = active_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcnt_i != CommitAt) |=> $stable(active_q)); // R3
  AST_COMMIT_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !we_i) |=> active_q == $past(shadow_q)); // R4
  AST_COMMIT_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && we_i) |=> active_q == $past(wdata_i)); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(shadow_q)); // R9

endmodule

// File: rtl/disp_ctrl_latch.sv
module disp_ctrl_latch
  import disp_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned HCNT_W       = 11,
  parameter int unsigned COMMIT_CYCLE = 144
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [HCNT_W-1:0] hcnt_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              blank_o,
  output logic              sprite_off_o,
  output logic [DATA_W-1:0] bg_color_o,
  output logic [DATA_W-1:0] vofs_o,
  output logic [DATA_W-1:0] name_base_o,
  output logic [DATA_W-1:0] color_base_o,
  output logic [DATA_W-1:0] pattern_base_o,
  output logic [DATA_W-1:0] sprite_base_o
);

  localparam logic [ADDR_W-1:0] LastAddr = ADDR_W'(IMM_BASE + NUM_IMM - 1);
  localparam logic [HCNT_W-1:0] CommitAt = HCNT_W'(COMMIT_CYCLE);

  logic                           def_we;
  logic [NUM_IMM-1:0]             imm_we;
  logic [NUM_IMM-1:0][DATA_W-1:0] imm_q;
  defer_t                         def_wdata, def_active;

  assign def_wdata = defer_t'(wr_data_i[DEFER_W-1:0]);

  dcr_wr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .def_we_o (def_we),
    .imm_we_o (imm_we)
  );

  dcr_imm_bank #(.DATA_W(DATA_W)) u_imm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (imm_we),
    .wdata_i(wr_data_i),
    .q_o    (imm_q)
  );

  dcr_defer_stage #(.HCNT_W(HCNT_W), .COMMIT_CYCLE(COMMIT_CYCLE)) u_defer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (def_we),
    .wdata_i (def_wdata),
    .hcnt_i  (hcnt_i),
    .active_o(def_active)
  );

  assign mode_o         = def_active.mode;
  assign blank_o        = def_active.blank;
  assign sprite_off_o   = def_active.sprite_off;
  assign bg_color_o     = imm_q[IMM_BG];
  assign vofs_o         = imm_q[IMM_VOFS];
  assign name_base_o    = imm_q[IMM_NAME];
  assign color_base_o   = imm_q[IMM_COLOR];
  assign pattern_base_o = imm_q[IMM_PAT];
  assign sprite_base_o  = imm_q[IMM_SPR];

  AST_UNMAPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i > LastAddr && hcnt_i != CommitAt) |=>
      $stable({mode_o, blank_o, sprite_off_o, bg_color_o, vofs_o, name_base_o,
               color_base_o, pattern_base_o, sprite_base_o})); // R7

endmodule

// File: tb/disp_ctrl_latch_tb.sv
`timescale 1ns/1ps
module disp_ctrl_latch_tb;

  localparam int LINE   = 256;
  localparam int COMMIT = 144;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] data = '0;
  logic [10:0] hcnt = '0;

  logic [4:0] mode;
  logic       blank, spr_off;
  logic [7:0] bg, vofs, nb, cb, pb, sb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  disp_ctrl_latch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data),
    .hcnt_i(hcnt), .mode_o(mode), .blank_o(blank), .sprite_off_o(spr_off),
    .bg_color_o(bg), .vofs_o(vofs), .name_base_o(nb), .color_base_o(cb),
    .pattern_base_o(pb), .sprite_base_o(sb)
  );

  // reference model from the requirements
  logic [6:0] sh_m, act_m, nsh_m;
  logic [7:0] imm_m [6];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_m  <= 7'h20;
      act_m <= 7'h20;
      for (int i = 0; i < 6; i++) imm_m[i] <= 8'h00;
    end else begin
      nsh_m = (we && addr == 6'd0) ? data[6:0] : sh_m;
      sh_m <= nsh_m;
      if (hcnt == 11'(COMMIT)) act_m <= nsh_m;
      if (we && addr >= 6'd1 && addr <= 6'd6) imm_m[addr-1] <= data;
    end
  end

  wire [6:0]  dfr_out = {spr_off, blank, mode};
  wire [47:0] imm_out = {sb, pb, cb, nb, vofs, bg};
  wire [47:0] imm_exp = {imm_m[5], imm_m[4], imm_m[3], imm_m[2], imm_m[1], imm_m[0]};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic w, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    chk("R3 deferred outputs per cycle", 64'(dfr_out), 64'(act_m));
    chk("R6 immediate outputs per cycle", 64'(imm_out), 64'(imm_exp));
    hcnt = (hcnt == 11'(LINE - 1)) ? 11'd0 : hcnt + 11'd1;
    we = w; addr = a; data = d;
  endtask

  function automatic logic [10:0] nxt(input logic [10:0] h);
    return (h == 11'(LINE - 1)) ? 11'd0 : h + 11'd1;
  endfunction

  task automatic wr_at(input int h, input logic [5:0] a, input logic [7:0] d);
    while (nxt(hcnt) != 11'(h)) tick(1'b0, 6'd0, 8'd0);
    tick(1'b1, a, d);
  endtask

  task automatic run_to(input int h);
    while (hcnt != 11'(h)) tick(1'b0, 6'd0, 8'd0);
  endtask

  task automatic run_line;
    tick(1'b0, 6'd0, 8'd0);
    run_to(COMMIT + 1);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 deferred reset", 64'(dfr_out), 64'h20);
    chk("R1 immediate reset", 64'(imm_out), 64'h0);
    rst_n = 1'b1;
    chk("R1 deferred after release", 64'(dfr_out), 64'h20);

    // R2: mid-line write held back, then R3 commit
    wr_at(50, 6'd0, 8'h43);
    run_to(COMMIT);
    chk("R2 write held before commit", 64'(dfr_out), 64'h20);
    tick(1'b0, 6'd0, 8'd0);
    chk("R3 write visible after commit", 64'(dfr_out), 64'h43);

    // R4: last of several writes wins
    wr_at(10, 6'd0, 8'h05);
    wr_at(20, 6'd0, 8'h25);
    wr_at(30, 6'd0, 8'h0A);
    run_to(COMMIT);
    chk("R4 no change before commit", 64'(dfr_out), 64'h43);
    tick(1'b0, 6'd0, 8'd0);
    chk("R4 last write applied", 64'(dfr_out), 64'h0A);

    // R5: write on commit cycle included, one later is not
    wr_at(COMMIT, 6'd0, 8'h31);
    tick(1'b0, 6'd0, 8'd0);
    chk("R5 commit-cycle write included", 64'(dfr_out), 64'h31);
    wr_at(COMMIT + 1, 6'd0, 8'h82);
    tick(1'b0, 6'd0, 8'd0);
    chk("R5 late write deferred", 64'(dfr_out), 64'h31);
    run_to(COMMIT + 1);
    chk("R5 late write next line", 64'(dfr_out), 64'h02);

    // R8: idle lines keep value
    run_line();
    run_line();
    chk("R8 idle commits keep value", 64'(dfr_out), 64'h02);

    // R6: immediate fields at arbitrary line positions
    wr_at(20, 6'd1, 8'hA5);
    tick(1'b0, 6'd0, 8'd0);
    chk("R6 bg colour next cycle", 64'(bg), 64'hA5);
    wr_at(COMMIT, 6'd2, 8'h3C);
    tick(1'b0, 6'd0, 8'd0);
    chk("R6 vofs next cycle", 64'(vofs), 64'h3C);
    wr_at(200, 6'd6, 8'h77);
    tick(1'b0, 6'd0, 8'd0);
    chk("R6 sprite base next cycle", 64'(sb), 64'h77);

    // R9: no strobe, no effect
    for (int i = 0; i < 300; i++) tick(1'b0, 6'd0, 8'hFF);
    chk("R9 deferred unchanged without strobe", 64'(dfr_out), 64'h02);
    for (int i = 0; i < 20; i++) tick(1'b0, 6'd1, 8'h00);
    tick(1'b0, 6'd0, 8'd0);
    chk("R9 bg unchanged without strobe", 64'(bg), 64'hA5);

    // R7: unmapped addresses
    for (int a = 7; a < 64; a++) tick(1'b1, 6'(a), 8'hFF);
    run_line();
    chk("R7 deferred unchanged by unmapped", 64'(dfr_out), 64'h02);
    chk("R7 immediates unchanged by unmapped", 64'(imm_out), 64'h770000003CA5);

    // sweep all addresses at varied line positions
    for (int k = 0; k < 3; k++)
      for (int a = 0; a < 64; a++)
        wr_at((a * 29 + k * 83) % LINE, 6'(a), 8'((a * 37 + k * 101 + 13) & 8'hFF));
    run_line();
    chk("R4 sweep final deferred", 64'(dfr_out), 64'(act_m));
    finish_up();
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

endmodule